// File: doc/BRIEF.md
# Table-Coded Clock Divider Bank

This block produces a set of clock-enable pulses from a single fast reference clock. Each output divides the reference by a ratio that a 4-bit code selects from a fixed, sparse table of non-power-of-two divisors. Software writes the codes for all outputs into one staging register through a simple write/read port. The codes take effect only when software sets a commit bit in a second register, so every output moves to its new ratio from the same point.

Each output also has a mask of permitted codes. A code that is not permitted for an output is rejected for that output alone. Each divider switches ratio only at the end of the period it is running, so no period is ever shortened. Downstream logic uses each output as a one-cycle enable qualifier on the reference clock.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset every ratio field reads as code 0, the commit bit (address 1, bit 31) reads as 0, and every output pulses with period 2.
- R2: Codes select divisors as follows: 0→2, 1→3, 2→4, 3→6, 4→8, 5→12, 6→16, 7→18, 8→24, 9→32, 10→36, 11→48, 13→72, 14→96. Codes 12 and 15 are never accepted.
- R3: Address 0 holds the staged codes, with output 0 in bits 23:20, output 1 in bits 19:16, output 2 in bits 11:8, output 3 in bits 7:4 and output 4 in bits 3:0. All other bits of address 0 read as 0.
- R4: Writing the staged codes does not change any output period until a commit.
- R5: Writing 1 to bit 31 at address 1 starts a commit. Bit 31 reads as 1 in the cycle after the write and clears itself one cycle later, when all staged codes are loaded together.
- R6: A code is accepted for an output only if bit <code> of that output's mask is set. Outputs 0 to 3 use mask 0x6fff and output 4 uses mask 0x677c. A rejected code leaves that output's staged code unchanged, while other fields in the same write are still updated.
- R7: An output takes up a new ratio only at the end of its current period. Every observed period equals either the old divisor or the new divisor.
- R8: Each output is high for exactly one reference cycle in every N cycles, where N is its active divisor.
- R9: Writing 0 to bit 31 at address 1 starts no commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 staged codes, 1 commit control) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| div_en_o | output | 5 | One-cycle enable pulse per output |

## Verification
The bench writes each of the 16 codes into all fields at once. It checks the staged readback against the per-output masks, so a design with a wrong mask, or one that applies a rejected code, shows a wrong field value or a wrong period on output 4. It measures every pulse-to-pulse interval around each commit. A divider that switches ratio mid-period produces an interval that matches neither the old nor the new divisor, and a commit that does not self-clear, or that fires on a zero write, is visible in the bit 31 readback and in period changes that happen too early. One write with a different code in each field ties each bit offset to its output; swapped offsets would show up as swapped periods.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int unsigned CODE_W  = 4;
  localparam int unsigned MAX_DIV = 96;
  localparam int unsigned CNT_W   = $clog2(MAX_DIV);

  // divisor for a code; prohibited codes fall back to 2 (never committed)
  function automatic logic [7:0] div_of(input logic [CODE_W-1:0] code);
    case (code)
      4'd0:  div_of = 8'd2;
      4'd1:  div_of = 8'd3;
      4'd2:  div_of = 8'd4;
      4'd3:  div_of = 8'd6;
      4'd4:  div_of = 8'd8;
      4'd5:  div_of = 8'd12;
      4'd6:  div_of = 8'd16;
      4'd7:  div_of = 8'd18;
      4'd8:  div_of = 8'd24;
      4'd9:  div_of = 8'd32;
      4'd10: div_of = 8'd36;
      4'd11: div_of = 8'd48;
      4'd13: div_of = 8'd72;
      4'd14: div_of = 8'd96;
      default: div_of = 8'd2;
    endcase
  endfunction
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter int unsigned N_OUT      = 5,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 2,
  parameter int unsigned COMMIT_BIT = 31,
  parameter logic [N_OUT*8-1:0]  FIELD_OFFS = {8'd0, 8'd4, 8'd8, 8'd16, 8'd20},
  parameter logic [N_OUT*16-1:0] CODE_MASKS = {16'h677c, 16'h6fff, 16'h6fff, 16'h6fff, 16'h6fff}
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     reg_we_i,
  input  logic [ADDR_W-1:0]        reg_addr_i,
  input  logic [DATA_W-1:0]        reg_wdata_i,
  output logic [DATA_W-1:0]        reg_rdata_o,
  output logic [N_OUT*CODE_W-1:0]  committed_o
);
  localparam logic [ADDR_W-1:0] A_STAGE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(1);

  logic [CODE_W-1:0] staged_q [N_OUT];
  logic [CODE_W-1:0] commit_q [N_OUT];
  logic              pending_q;

  wire wr_stage = reg_we_i && (reg_addr_i == A_STAGE);
  wire wr_ctrl  = reg_we_i && (reg_addr_i == A_CTRL);

  for (genvar k = 0; k < N_OUT; k++) begin : g_field
    localparam int unsigned OFF = int'(FIELD_OFFS[k*8 +: 8]);
    localparam logic [15:0] MSK = CODE_MASKS[k*16 +: 16];
    logic [CODE_W-1:0] wr_code;
    logic              ok;
    assign wr_code = reg_wdata_i[OFF +: CODE_W];
    assign ok      = MSK[wr_code];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        staged_q[k] <= '0;
        commit_q[k] <= '0;
      end else begin
        if (wr_stage && ok) staged_q[k] <= wr_code;
        if (pending_q)      commit_q[k] <= staged_q[k];
      end
    end

    assign committed_o[k*CODE_W +: CODE_W] = commit_q[k];

    AST_REJECT_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_stage && !ok) |=> $stable(staged_q[k])); // R6
    AST_HOLD_UNTIL_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pending_q |=> $stable(commit_q[k])); // R4
    AST_COMMIT_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pending_q) |-> (commit_q[k] == $past(staged_q[k]))); // R5
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             pending_q <= 1'b0;
    else if (pending_q)                      pending_q <= 1'b0;
    else if (wr_ctrl && reg_wdata_i[COMMIT_BIT]) pending_q <= 1'b1;
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == A_STAGE) begin
      for (int k = 0; k < N_OUT; k++)
        reg_rdata_o[int'(FIELD_OFFS[k*8 +: 8]) +: CODE_W] = staged_q[k];
    end else if (reg_addr_i == A_CTRL) begin
      reg_rdata_o[COMMIT_BIT] = pending_q;
    end
  end

  AST_COMMIT_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_q |=> !pending_q); // R5
  AST_ZERO_NO_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pending_q && !(wr_ctrl && reg_wdata_i[COMMIT_BIT])) |=> !pending_q); // R9
endmodule

// File: rtl/clkdiv_lane.sv
module clkdiv_lane
  import clkdiv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic              en_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic [7:0]       nxt_div;

  wire wrap = (cnt_q == lim_q);
  assign nxt_div = div_of(code_i) - 8'd1;

  // ratio reloads only at period end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= CNT_W'(1);
    end else if (wrap) begin
      cnt_q <= '0;
      lim_q <= nxt_div[CNT_W-1:0];
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign en_o = wrap;

  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |=> !en_o); // R8
  AST_RATIO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_o |=> $stable(lim_q)); // R7
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim_q); // R8
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int unsigned N_OUT  = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2,
  parameter logic [N_OUT*8-1:0]  FIELD_OFFS = {8'd0, 8'd4, 8'd8, 8'd16, 8'd20},
  parameter logic [N_OUT*16-1:0] CODE_MASKS = {16'h677c, 16'h6fff, 16'h6fff, 16'h6fff, 16'h6fff}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [N_OUT-1:0]  div_en_o
);
  logic [N_OUT*CODE_W-1:0] committed;

  clkdiv_regs #(
    .N_OUT(N_OUT), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .COMMIT_BIT(DATA_W-1),
    .FIELD_OFFS(FIELD_OFFS), .CODE_MASKS(CODE_MASKS)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .committed_o(committed)
  );

  for (genvar k = 0; k < N_OUT; k++) begin : g_lane
    clkdiv_lane u_lane (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .code_i(committed[k*CODE_W +: CODE_W]), .en_o(div_en_o[k])
    );
  end
endmodule

// File: tb/clkdiv_bank_tb.sv
module clkdiv_bank_tb;
  localparam int NO = 5;
  localparam int OFFS [NO] = '{20, 16, 8, 4, 0};
  localparam logic [15:0] MSKS [NO] = '{16'h6fff, 16'h6fff, 16'h6fff, 16'h6fff, 16'h677c};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NO-1:0] en;

  int checks = 0, errors = 0;
  int cyc = 0;
  int last_t [NO];
  int per [NO];
  bit seen [NO];
  int old_d [NO], new_d [NO];
  int odd_cnt = 0;
  int stg [NO];

  always #2 clk = ~clk;

  clkdiv_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .div_en_o(en)
  );

  function automatic int dv(input int c);
    case (c)
      0: dv = 2;   1: dv = 3;   2: dv = 4;   3: dv = 6;
      4: dv = 8;   5: dv = 12;  6: dv = 16;  7: dv = 18;
      8: dv = 24;  9: dv = 32;  10: dv = 36; 11: dv = 48;
      13: dv = 72; 14: dv = 96; default: dv = -1;
    endcase
  endfunction

  // interval monitor: every period must be the old or new divisor (R7, R8)
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int k = 0; k < NO; k++) seen[k] <= 1'b0;
    end else begin
      for (int k = 0; k < NO; k++) if (en[k]) begin
        if (seen[k]) begin
          per[k] <= cyc - last_t[k];
          if ((cyc - last_t[k]) != old_d[k] && (cyc - last_t[k]) != new_d[k])
            odd_cnt <= odd_cnt + 1;
        end
        seen[k] <= 1'b1;
        last_t[k] <= cyc;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1 d = rdata;
  endtask

  function automatic logic [31:0] exp_stage();
    logic [31:0] v = '0;
    for (int k = 0; k < NO; k++) v[OFFS[k] +: 4] = 4'(stg[k]);
    return v;
  endfunction

  task automatic check_periods(input string req);
    for (int k = 0; k < NO; k++) chk(req, per[k], dv(stg[k]));
  endtask

  task automatic commit_and_settle(input bit check_flag);
    logic [31:0] r;
    for (int k = 0; k < NO; k++) begin old_d[k] = per[k]; new_d[k] = dv(stg[k]); end
    wr(2'd1, 32'h8000_0000);
    rd(2'd1, r);
    if (check_flag) chk("R5 commit pending", int'(r[31]), 1);
    @(negedge clk); rd(2'd1, r);
    if (check_flag) chk("R5 commit self-clear", int'(r[31]), 0);
    repeat (260) @(negedge clk);
    for (int k = 0; k < NO; k++) old_d[k] = new_d[k];
  endtask

  initial begin
    logic [31:0] r;
    int fmask;
    for (int k = 0; k < NO; k++) begin stg[k] = 0; old_d[k] = 2; new_d[k] = 2; per[k] = 0; end
    fmask = 0;
    for (int k = 0; k < NO; k++) fmask |= (32'hf << OFFS[k]);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    // R1 reset state
    rd(2'd0, r); chk("R1 staged reset", int'(r), 0);
    rd(2'd1, r); chk("R1 commit reset", int'(r), 0);
    check_periods("R1 reset period");

    // sweep all codes into all fields at once (R2, R3, R4, R6, R7)
    for (int c = 0; c < 16; c++) begin
      logic [31:0] d = ~32'(fmask);
      for (int k = 0; k < NO; k++) d[OFFS[k] +: 4] = 4'(c);
      for (int k = 0; k < NO; k++) if (MSKS[k][c]) stg[k] = c;
      odd_cnt = 0;
      wr(2'd0, d);
      rd(2'd0, r); chk("R3 R6 staged readback", int'(r), int'(exp_stage()));
      repeat (200) @(negedge clk);
      for (int k = 0; k < NO; k++) chk("R4 no change before commit", per[k], old_d[k]);
      commit_and_settle(c < 2);
      check_periods("R2 R8 period after commit");
      chk("R7 no odd interval", odd_cnt, 0);
    end

    // distinct code per field ties offsets to outputs (R3)
    stg[0] = 2; stg[1] = 3; stg[2] = 4; stg[3] = 5; stg[4] = 6;
    wr(2'd0, 32'h0023_0456);
    rd(2'd0, r); chk("R3 field offsets", int'(r), 32'h0023_0456);
    commit_and_settle(1'b1);
    check_periods("R3 output mapping");

    // R9: zero write at the control address does not commit
    wr(2'd0, 32'h0000_0000);
    wr(2'd1, 32'h7fff_ffff);
    rd(2'd1, r); chk("R9 no pending", int'(r[31]), 0);
    repeat (260) @(negedge clk);
    for (int k = 0; k < NO; k++) chk("R9 periods held", per[k], dv(stg[k]));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule